// File: doc/BRIEF.md
# Wavefront Divergence Mask Stack

This block keeps the per-lane execution mask of one wavefront while its control flow diverges. Both sides of a branch are issued to every lane; lanes that are not on the current path are switched off by the mask. A sequencer sends one command per cycle: save the current mask before the clause that computes a branch condition, narrow the mask with a per-lane predicate, swap to the other side of the branch, restore one or more nesting levels, or take a conditional jump that restores levels only when no lane is left on the path.

The predicate arrives as one bit per lane, already reduced from a compare result to "non-zero". A stack of saved masks holds one entry per open nesting level, so a single restore or jump command can close several levels at once. The `skip` output tells the sequencer that no lane is active, so the next clause can be jumped over. Misuse of the stack (saving into a full stack, restoring more levels than exist, swapping sides with nothing saved) sets a sticky error flag and leaves the mask and the stack untouched.

Top module: `lanemask_ctl`

## Requirements
- R1: After reset the mask is all ones, the depth is 0, `err` is 0 and `skip` is 0.
- R2: A save command (code 1) on a stack with free room stores the current mask as a new level, raises the depth by one and leaves the mask unchanged.
- R3: A narrow command (code 2) sets the mask to the old mask AND `pred`; the depth does not change.
- R4: A swap command (code 3) sets the mask to the most recently saved mask AND NOT `pred`, leaving the depth unchanged; with depth 0 it is a fault (R8).
- R5: A restore command (code 4) with count n, 1 <= n <= depth, sets the mask to the entry saved n levels below the top of the stack (the one at position depth-n, counted from 0 at the bottom) and lowers the depth by n; a count of 0 changes nothing.
- R6: A jump command (code 5) acts as a restore with its count when the mask is all zero, and changes nothing when any lane is active.
- R7: `skip` is 1 exactly when the current mask has no bit set.
- R8: A save with the depth at its limit, a restore or taken jump whose count exceeds the depth, or a swap with depth 0 sets `err`, which stays set until reset; such a command changes neither the mask nor the depth.
- R9: While `cmd_valid` is 0, no command has any effect on the mask, the depth or `err`.
- R10: Code 0 and the unused codes 6 and 7 have no effect.
- R11: Every command takes effect on the clock edge where it is presented, and the new mask, depth, `skip` and `err` are visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd | input | 3 | Command code: 0 none, 1 save, 2 narrow, 3 swap, 4 restore, 5 jump |
| pred | input | LANES (64) | Per-lane predicate, 1 = condition true |
| pop_cnt | input | DW (4) | Number of levels for restore and jump |
| mask | output | LANES (64) | Current active-lane mask |
| skip | output | 1 | No lane active |
| depth | output | DW (4) | Number of saved levels |
| err | output | 1 | Sticky misuse flag |

## Verification
Directed sequences walk a two-level nested branch (save, narrow to the low half, swap to the high half, nested narrow to zero, taken jump, restore) so that a wrong stack index or a swap against the live mask instead of the saved one shows up as a wrong half. Predicates of all zeros, all ones and dense and sparse random words tell the AND-narrowing apart from replacement and drive the mask to zero often enough that jumps are both taken and not taken. Filling the stack to its limit, restoring more levels than exist, restoring zero levels and sending commands with `cmd_valid` low or unused codes separate the fault and no-op paths from the normal ones. A long random run with balanced saves and restores compares mask, depth, skip and error against a bench model every cycle.

// File: rtl/lanemask_pkg.sv
package lanemask_pkg;
  typedef enum logic [2:0] {
    LM_NONE    = 3'd0,
    LM_SAVE    = 3'd1,
    LM_NARROW  = 3'd2,
    LM_SWAP    = 3'd3,
    LM_RESTORE = 3'd4,
    LM_JUMP    = 3'd5
  } lm_cmd_e;

  localparam int unsigned LM_LANES_DEF = 64;
  localparam int unsigned LM_DEPTH_DEF = 8;
endpackage

// File: rtl/lanemask_dec.sv
module lanemask_dec #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned DW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd,
  input  logic [DW-1:0] pop_cnt,
  input  logic [DW-1:0] depth,
  input  logic          mask_zero,
  output logic          push_ok,
  output logic          narrow_ok,
  output logic          swap_ok,
  output logic          pop_ok,
  output logic          fault
);
  import lanemask_pkg::*;

  localparam logic [DW-1:0] FULL = DW'(DEPTH);

  logic is_save, is_narrow, is_swap, wants_pop;
  logic full_hit, empty_hit, deep_hit;

  always_comb begin
    is_save   = cmd_valid && (cmd == LM_SAVE);
    is_narrow = cmd_valid && (cmd == LM_NARROW);
    is_swap   = cmd_valid && (cmd == LM_SWAP);
    wants_pop = cmd_valid && ((cmd == LM_RESTORE) || ((cmd == LM_JUMP) && mask_zero));
    full_hit  = is_save && (depth == FULL);
    empty_hit = is_swap && (depth == '0);
    deep_hit  = wants_pop && (pop_cnt > depth);
    push_ok   = is_save && !full_hit;
    narrow_ok = is_narrow;
    swap_ok   = is_swap && !empty_hit;
    pop_ok    = wants_pop && !deep_hit && (pop_cnt != '0);
    fault     = full_hit || empty_hit || deep_hit;
  end

  // R8: a granted save never finds the stack at its limit
  a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |-> (depth < FULL));
  // R8: a granted restore never asks for more levels than exist
  a_r8_no_pop_deep: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok |-> (pop_cnt <= depth) && (pop_cnt != '0));
  // R9: nothing is granted without a valid command
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> !(push_ok || narrow_ok || swap_ok || pop_ok || fault));
endmodule

// File: rtl/lanemask_stack.sv
module lanemask_stack #(
  parameter int unsigned LANES = 64,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned DW = $clog2(DEPTH + 1),
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic [LANES-1:0] push_data,
  input  logic             pop_en,
  input  logic [DW-1:0]    pop_n,
  output logic [DW-1:0]    depth,
  output logic [LANES-1:0] top_q,
  output logic [LANES-1:0] rest_q
);
  logic [LANES-1:0] entry [DEPTH];
  logic [DW-1:0]    depth_q;
  logic [AW-1:0]    top_idx, rest_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (push_en && (depth_q == DW'(g))) entry[g] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       depth_q <= '0;
    else if (push_en) depth_q <= depth_q + DW'(1);
    else if (pop_en)  depth_q <= depth_q - pop_n;
  end

  always_comb begin
    top_idx  = AW'(depth_q - DW'(1));
    rest_idx = AW'(depth_q - pop_n);
    top_q    = (depth_q == '0) ? '0 : entry[top_idx];
    rest_q   = entry[rest_idx];
    depth    = depth_q;
  end

  // R2: a save adds exactly one level
  a_r2_push_depth: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |=> depth_q == $past(depth_q) + DW'(1));
  // R5: a restore removes exactly the requested number of levels
  a_r5_pop_depth: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |=> depth_q == $past(depth_q) - $past(pop_n));
  // R8: depth never exceeds the stack size
  a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DW'(DEPTH));
endmodule

// File: rtl/lanemask_ctl.sv
module lanemask_ctl #(
  parameter int unsigned LANES = lanemask_pkg::LM_LANES_DEF,
  parameter int unsigned DEPTH = lanemask_pkg::LM_DEPTH_DEF,
  localparam int unsigned DW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd,
  input  logic [LANES-1:0] pred,
  input  logic [DW-1:0]    pop_cnt,
  output logic [LANES-1:0] mask,
  output logic             skip,
  output logic [DW-1:0]    depth,
  output logic             err
);
  function automatic logic [LANES-1:0] narrow_fn(input logic [LANES-1:0] cur,
                                                 input logic [LANES-1:0] p);
    return cur & p;
  endfunction

  function automatic logic [LANES-1:0] swap_fn(input logic [LANES-1:0] saved,
                                               input logic [LANES-1:0] p);
    return saved & ~p;
  endfunction

  logic [LANES-1:0] mask_q, top_q, rest_q;
  logic             err_q, mask_zero;
  logic             push_ok, narrow_ok, swap_ok, pop_ok, fault;

  assign mask_zero = (mask_q == '0);

  lanemask_dec #(.DEPTH(DEPTH)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .pop_cnt   (pop_cnt),
    .depth     (depth),
    .mask_zero (mask_zero),
    .push_ok   (push_ok),
    .narrow_ok (narrow_ok),
    .swap_ok   (swap_ok),
    .pop_ok    (pop_ok),
    .fault     (fault)
  );

  lanemask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (push_ok),
    .push_data (mask_q),
    .pop_en    (pop_ok),
    .pop_n     (pop_cnt),
    .depth     (depth),
    .top_q     (top_q),
    .rest_q    (rest_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      err_q  <= 1'b0;
    end else begin
      if (fault)          err_q  <= 1'b1;
      if (narrow_ok)      mask_q <= narrow_fn(mask_q, pred);
      else if (swap_ok)   mask_q <= swap_fn(top_q, pred);
      else if (pop_ok)    mask_q <= rest_q;
    end
  end

  assign mask = mask_q;
  assign skip = mask_zero;
  assign err  = err_q;

  // R8: the error flag holds until reset
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R8: a faulting command leaves mask and depth untouched
  a_r8_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> $stable(mask_q) && $stable(depth));
  // R3: narrowing never turns a lane on
  a_r3_narrow_only: assert property (@(posedge clk) disable iff (!rst_n)
    narrow_ok |=> (mask_q & ~$past(mask_q)) == '0);
  // R2: a save keeps the live mask
  a_r2_save_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    push_ok |=> $stable(mask_q));
  // R9: idle cycles change nothing
  a_r9_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(mask_q) && $stable(depth) && $stable(err_q));
endmodule

// File: tb/test_lanemask_ctl.sv
module test_lanemask_ctl;
  localparam int LANES = 64;
  localparam int DEPTH = 8;
  localparam int DW    = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [2:0]       cmd = 3'd0;
  logic [LANES-1:0] pred = '0;
  logic [DW-1:0]    pop_cnt = '0;
  logic [LANES-1:0] mask;
  logic             skip;
  logic [DW-1:0]    depth;
  logic             err;

  always #4 clk = ~clk;

  lanemask_ctl #(.LANES(LANES), .DEPTH(DEPTH)) i_lanemask_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd), .pred(pred),
    .pop_cnt(pop_cnt), .mask(mask), .skip(skip), .depth(depth), .err(err)
  );

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  logic [LANES-1:0] m_mask;
  logic [LANES-1:0] m_stk [DEPTH];
  int               m_depth;
  logic             m_err;

  function automatic string tag_of(input bit v, input int c, input int n);
    if (!v) return "R9";
    case (c)
      1: return (m_depth >= DEPTH) ? "R8" : "R2";
      2: return "R3";
      3: return (m_depth == 0) ? "R8" : "R4";
      4: return (n > m_depth) ? "R8" : "R5";
      5: return (m_mask == 0 && n > m_depth) ? "R8" : "R6";
      default: return "R10";
    endcase
  endfunction

  function automatic void restore_levels(input int n);
    if (n == 0) return;
    if (n > m_depth) begin m_err = 1'b1; return; end
    m_depth = m_depth - n;
    m_mask  = m_stk[m_depth];
  endfunction

  function automatic void model_step(input bit v, input int c,
                                     input logic [LANES-1:0] p, input int n);
    if (!v) return;
    if (c == 1) begin
      if (m_depth >= DEPTH) m_err = 1'b1;
      else begin m_stk[m_depth] = m_mask; m_depth++; end
    end else if (c == 2) begin
      m_mask = m_mask & p;
    end else if (c == 3) begin
      if (m_depth == 0) m_err = 1'b1;
      else m_mask = m_stk[m_depth-1] & ~p;
    end else if (c == 4) begin
      restore_levels(n);
    end else if (c == 5) begin
      if (m_mask == 0) restore_levels(n);
    end
  endfunction

  task automatic compare(input string tag);
    n_checks++;
    if (mask !== m_mask || depth !== DW'(m_depth) || err !== m_err ||
        skip !== (m_mask == 0)) begin
      n_errors++;
      $display("FAIL %s (R11 timing): mask=%h depth=%0d err=%b skip=%b expected mask=%h depth=%0d err=%b skip=%b",
               tag, mask, depth, err, skip, m_mask, m_depth, m_err, (m_mask == 0));
    end
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_mask = '1; m_depth = 0; m_err = 1'b0;
    #1 compare("R1");
  endtask

  task automatic issue(input bit v, input int c, input logic [LANES-1:0] p, input int n);
    string t;
    @(negedge clk);
    cmd_valid = v; cmd = 3'(c); pred = p; pop_cnt = DW'(n);
    t = tag_of(v, c, n);
    model_step(v, c, p, n);
    @(posedge clk);
    #2 compare(t);
  endtask

  function automatic logic [LANES-1:0] rnd_pred();
    int k = $urandom_range(0, 9);
    logic [LANES-1:0] a = {$urandom, $urandom};
    logic [LANES-1:0] b = {$urandom, $urandom};
    if (k == 0) return '0;
    if (k == 1) return '1;
    if (k < 5)  return a & b;
    return a | b;
  endfunction

  localparam logic [LANES-1:0] LOW  = 64'h0000_0000_FFFF_FFFF;
  localparam logic [LANES-1:0] HIGH = 64'hFFFF_FFFF_0000_0000;

  initial begin
    void'($urandom(32'h5eed_1234));
    reset_dut();                      // R1
    issue(1, 1, '0, 0);               // R2 save
    issue(1, 2, LOW, 0);              // R3 narrow to low half
    issue(1, 3, LOW, 0);              // R4 swap to high half
    issue(1, 1, '0, 0);               // R2 nested save
    issue(1, 2, LOW, 0);              // R3 narrow to zero, R7 skip
    issue(1, 5, '0, 1);               // R6 taken jump -> high half
    issue(1, 4, '0, 1);               // R5 restore -> all ones
    issue(1, 5, '0, 1);               // R6 not taken
    issue(1, 4, '0, 0);               // R5 count zero
    issue(1, 4, '0, 1);               // R8 underflow
    issue(1, 2, '0, 0);               // R8 sticky after further command
    reset_dut();                      // R1 clears err
    for (int i = 0; i < DEPTH + 1; i++) issue(1, 1, '0, 0); // R8 overflow on last
    issue(0, 4, '0, 3);               // R9
    issue(1, 7, '0, 3);               // R10
    issue(1, 6, '0, 3);               // R10
    issue(1, 2, HIGH, 0);             // R3
    issue(1, 4, '0, DEPTH);           // R5 restore all levels
    issue(1, 3, '0, 0);               // R8 swap with empty stack
    reset_dut();
    for (int i = 0; i < 3000; i++) begin
      int c, n, r;
      bit v;
      if (i % 600 == 599) reset_dut();
      r = $urandom_range(0, 99);
      v = (r >= 8);
      r = $urandom_range(0, 99);
      if (r < 25) c = 1; else if (r < 50) c = 2; else if (r < 62) c = 3;
      else if (r < 80) c = 4; else if (r < 95) c = 5; else c = $urandom_range(6, 7);
      n = $urandom_range(0, 3);
      issue(v, c, rnd_pred(), n);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule